// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the register side of a serial port. It sits on an APB bus and holds a control word, a derived status word and a receive FIFO. Bytes arrive from a deserializer on a byte stream and are queued in the FIFO while reception is enabled. Software pops them by reading the data register. A write to the data register hands the low byte to a serializer on a second byte stream, but only while transmission is enabled. Bit timing, parity and flow-control signalling live outside this block.

The receive stream never applies back-pressure: `rx_ready` is held high. A byte offered while reception is disabled is discarded. A byte offered while the FIFO is full is discarded and flags an overrun. The transmit stream does apply back-pressure: `tx_valid` is raised during the APB access phase of an enabled data write, and it stays up, with the bus stalled through `pready`, until the serializer accepts it with `tx_ready`.

A single interrupt line pulses for one cycle after each stored receive byte, and after each accepted transmit byte, whenever the matching interrupt enable is set.

Top module: `serial_front_end`

## Requirements
- R1: After reset the control word reads 0x00000000, the receive FIFO is empty and the status word reads 0x00000006.
- R2: Only `paddr[7:0]` is decoded. The data register is at 0x00 and also at 0x03, status is at 0x04, control is at 0x08, scaler is at 0x0C and FIFO debug is at 0x10. A read of any other offset returns 0. `pslverr` is always 0.
- R3: Control is a 32-bit read/write word. Bit 0 enables reception, bit 1 enables transmission, bit 2 enables the receive interrupt and bit 3 enables the transmit interrupt. The other bits are stored and read back unchanged.
- R4: A byte offered on the receive stream is stored in arrival order only while control bit 0 is set; otherwise it has no effect. `rx_ready` is always 1.
- R5: A data-register read returns the oldest stored byte in bits 7:0 and removes it. A read with the FIFO empty returns 0 and changes nothing.
- R6: Status bit 0 is set while the FIFO is not empty, bit 8 while it holds at least DEPTH/2 bytes and bit 10 while it holds DEPTH bytes. Bits 1 and 2 read 1. Bits 3, 5, 6, 7 and 9 and bits 31:11 read 0.
- R7: A byte offered with reception enabled and the FIFO holding DEPTH bytes is dropped and sets status bit 4, which stays set until reset.
- R8: A data write with control bit 1 set raises `tx_valid` with `pwdata[7:0]` on `tx_data`, and holds `pready` low until `tx_ready` is seen. With bit 1 clear, the write completes without any `tx_valid`.
- R9: `irq` is high for the one cycle after a receive byte is stored with control bit 2 set, or after a transmit byte is accepted with control bit 3 set.
- R10: Writes to status, scaler, FIFO debug and unmapped offsets change nothing. Scaler and FIFO debug read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address, low 8 bits decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, low while a transmit byte waits |
| pslverr | output | 1 | APB error, tied 0 |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Always 1, no receive back-pressure |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serializer accepts the byte |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions watch, on every cycle, four things: a stalled transmit byte always holds the bus, the FIFO count never exceeds its depth, a pop on an empty FIFO leaves it empty, and an overrun flag never clears. They also check that an interrupt pulse is always preceded by activity on one of the two streams. The ordering of popped bytes, the exact status word at each occupancy, aliasing through the high address bits, and which enable combinations produce a pulse can only be shown by the bench. It shows them by comparing every read against a queue model under random traffic and a random serializer stall pattern.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic [2:0] {
    RG_DATA, RG_STAT, RG_CTRL, RG_SCAL, RG_DBG, RG_NONE
  } reg_sel_e;

  localparam int CB_RX_EN  = 0;
  localparam int CB_TX_EN  = 1;
  localparam int CB_RX_IE  = 2;
  localparam int CB_TX_IE  = 3;

  localparam int SB_RDY    = 0;
  localparam int SB_SHE    = 1;
  localparam int SB_TFE    = 2;
  localparam int SB_OVR    = 4;
  localparam int SB_RHALF  = 8;
  localparam int SB_RFULL  = 10;

  localparam logic [7:0] OFS_DATA  = 8'h00;
  localparam logic [7:0] OFS_DATA3 = 8'h03;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_SCAL  = 8'h0C;
  localparam logic [7:0] OFS_DBG   = 8'h10;
endpackage

// File: rtl/sfe_rx_fifo.sv
module sfe_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = empty ? '0 : mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/sfe_addr_dec.sv
module sfe_addr_dec
  import sfe_pkg::*;
(
  input  logic [7:0] ofs,
  output reg_sel_e   sel
);
  always_comb begin
    unique case (ofs)
      OFS_DATA, OFS_DATA3: sel = RG_DATA;
      OFS_STAT:            sel = RG_STAT;
      OFS_CTRL:            sel = RG_CTRL;
      OFS_SCAL:            sel = RG_SCAL;
      OFS_DBG:             sel = RG_DBG;
      default:             sel = RG_NONE;
    endcase
  end
endmodule

// File: rtl/sfe_status.sv
module sfe_status
  import sfe_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          full,
  input  logic          drop,
  output logic [31:0]   word
);
  logic ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ovr_q <= 1'b0;
    else if (drop) ovr_q <= 1'b1;
  end

  always_comb begin
    word           = '0;
    word[SB_RDY]   = (count != '0);
    word[SB_SHE]   = 1'b1;
    word[SB_TFE]   = 1'b1;
    word[SB_OVR]   = ovr_q;
    word[SB_RHALF] = (count >= CW'(HALF));
    word[SB_RFULL] = full;
  end

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
endmodule

// File: rtl/serial_front_end.sv
module serial_front_end
  import sfe_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  reg_sel_e      sel;
  logic [31:0]   ctrl_q;
  logic [31:0]   stat_w;
  logic [7:0]    head;
  logic [CW-1:0] cnt;
  logic          f_full, f_empty;
  logic          acc, done, pop, rx_store, rx_drop, irq_q;

  sfe_addr_dec u_dec (.ofs(paddr[7:0]), .sel(sel));

  assign acc      = psel && penable;
  assign tx_valid = acc && pwrite && (sel == RG_DATA) && ctrl_q[CB_TX_EN];
  assign tx_data  = pwdata[7:0];
  assign pready   = !(tx_valid && !tx_ready);
  assign pslverr  = 1'b0;
  assign done     = acc && pready;
  assign pop      = done && !pwrite && (sel == RG_DATA);
  assign rx_ready = 1'b1;
  assign rx_store = rx_valid && ctrl_q[CB_RX_EN] && !f_full;
  assign rx_drop  = rx_valid && ctrl_q[CB_RX_EN] && f_full;

  sfe_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_store), .din(rx_data),
    .pop(pop), .dout(head), .count(cnt), .full(f_full), .empty(f_empty)
  );

  sfe_status #(.DEPTH(DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_n), .count(cnt), .full(f_full),
    .drop(rx_drop), .word(stat_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (done && pwrite && (sel == RG_CTRL)) ctrl_q <= pwdata;
      irq_q <= (rx_store && ctrl_q[CB_RX_IE]) ||
               (tx_valid && tx_ready && ctrl_q[CB_TX_IE]);
    end
  end
  assign irq = irq_q;

  always_comb begin
    prdata = '0;
    if (acc && !pwrite) begin
      case (sel)
        RG_DATA: prdata = {24'h0, head};
        RG_STAT: prdata = stat_w;
        RG_CTRL: prdata = ctrl_q;
        default: prdata = '0;
      endcase
    end
  end

  // R8
  tx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |-> !pready);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_valid || tx_valid));

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && f_full && !pop) |=> f_full);
endmodule

// File: tb/tb_serial_front_end.sv
module tb_serial_front_end;
  localparam int DEPTH = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        rx_valid = 0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        irq;

  serial_front_end #(.ADDR_W(12), .DEPTH(DEPTH)) dut (.*);

  always #2 clk = ~clk;

  int vecs = 0, bad = 0, tx_cnt = 0;
  logic [7:0]  tx_last;
  bit          stall_rand = 0;
  logic [7:0]  q[$];
  logic [31:0] m_ctrl = '0;
  bit          m_ovr = 0;

  always @(negedge clk) tx_ready <= stall_rand ? ($urandom % 3 == 0) : 1'b1;
  always @(negedge clk) begin
    #1;
    if (tx_valid && tx_ready) begin tx_cnt++; tx_last = tx_data; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = 32'h6;
    s[0]  = q.size() != 0;
    s[4]  = m_ovr;
    s[8]  = q.size() >= DEPTH / 2;
    s[10] = q.size() == DEPTH;
    return s;
  endfunction

  task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output logic irq_after);
    @(negedge clk); psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = wd;
    @(negedge clk); penable = 1;
    #1;
    while (!pready) begin @(negedge clk); #1; end
    rd = prdata;
    if (pslverr !== 1'b0) chk("R2 pslverr", {31'h0, pslverr}, 32'h0);
    @(posedge clk); @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
    irq_after = irq;
  endtask

  task automatic push(input logic [7:0] d);
    logic ei;
    ei = m_ctrl[0] && m_ctrl[2] && q.size() < DEPTH;
    if (m_ctrl[0]) begin
      if (q.size() < DEPTH) q.push_back(d); else m_ovr = 1;
    end
    @(negedge clk); rx_valid = 1; rx_data = d;
    #1 chk("R4 rx_ready", {31'h0, rx_ready}, 32'h1);
    @(negedge clk); rx_valid = 0;
    chk("R9 irq after rx", {31'h0, irq}, {31'h0, ei});
  endtask

  task automatic rd_data(input logic [11:0] a);
    logic [31:0] r; logic i; logic [31:0] e;
    e = q.size() ? {24'h0, q.pop_front()} : 32'h0;
    apb(0, a, 0, r, i);
    chk("R5 data pop", r, e);
  endtask

  task automatic rd_stat();
    logic [31:0] r; logic i;
    apb(0, 12'h004, 0, r, i);
    chk("R6 R7 status", r, exp_stat());
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    logic [31:0] r; logic i;
    apb(1, 12'h008, v, r, i);
    m_ctrl = v;
  endtask

  task automatic wr_data(input logic [31:0] v);
    logic [31:0] r; logic i; int n;
    n = tx_cnt;
    apb(1, 12'h000, v, r, i);
    chk("R9 irq after tx", {31'h0, i}, {31'h0, m_ctrl[1] && m_ctrl[3]});
    if (m_ctrl[1]) begin
      chk("R8 tx count", tx_cnt, n + 1);
      chk("R8 tx byte", {24'h0, tx_last}, {24'h0, v[7:0]});
    end else chk("R8 tx gated", tx_cnt, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [31:0] r; logic i;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    apb(0, 12'h008, 0, r, i); chk("R1 ctrl reset", r, 0);
    apb(0, 12'h004, 0, r, i); chk("R1 status reset", r, 32'h6);
    rd_data(12'h000);
    // R4: disabled receive ignored
    push(8'h3C); rd_stat();
    wr_ctrl(32'h5);
    push(8'hA5);
    @(negedge clk); chk("R9 pulse one cycle", {31'h0, irq}, 0);
    rd_stat();
    rd_data(12'h003);  // R2 alias offset
    rd_stat();
    // R6 R7 fill, overflow, drain
    for (int k = 0; k < DEPTH; k++) begin
      push(8'(k + 8'h40));
      if (k == DEPTH / 2 - 2 || k == DEPTH / 2 - 1 || k == DEPTH - 1) rd_stat();
    end
    push(8'hEE);
    rd_stat();
    for (int k = 0; k < DEPTH; k++) rd_data(12'h000);
    rd_data(12'h000);
    rd_stat();
    // R10 ignored writes
    apb(1, 12'h004, 32'hFFFF_FFFF, r, i);
    apb(1, 12'h00C, 32'hFFFF_FFFF, r, i);
    apb(1, 12'h010, 32'hFFFF_FFFF, r, i);
    apb(1, 12'h040, 32'hFFFF_FFFF, r, i);
    rd_stat();
    apb(0, 12'h008, 0, r, i); chk("R10 ctrl kept", r, m_ctrl);
    apb(0, 12'h00C, 0, r, i); chk("R10 scaler zero", r, 0);
    apb(0, 12'h010, 0, r, i); chk("R10 debug zero", r, 0);
    apb(0, 12'h040, 0, r, i); chk("R2 unmapped zero", r, 0);
    apb(0, 12'h108, 0, r, i); chk("R2 high bits ignored", r, m_ctrl);
    // R3 full word
    wr_ctrl(32'h8000_1F5A);
    apb(0, 12'h008, 0, r, i); chk("R3 ctrl readback", r, 32'h8000_1F5A);
    // R8 transmit
    wr_ctrl(32'h0); wr_data(32'h11);
    wr_ctrl(32'hA); stall_rand = 1; wr_data(32'h1234_56C3);
    // random mix
    for (int it = 0; it < 3000; it++) begin
      int op = $urandom % 8;
      case (op)
        0, 1, 2: push(8'($urandom));
        3, 4:    rd_data(($urandom % 2) ? 12'h003 : 12'h000);
        5:       rd_stat();
        6:       wr_data($urandom);
        default: begin
          logic [31:0] v = $urandom;
          if ($urandom % 4 != 0) v[0] = 1'b1;
          wr_ctrl(v);
          apb(0, 12'h008, 0, r, i); chk("R3 ctrl random", r, v);
        end
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule